// File: doc/BRIEF.md
# Prioritized Interrupt Latch and Vector Arbiter

This block collects the interrupt requests of a small 16-bit processor core and, on demand, decides which one the core takes next. Six sources feed it: a macro-instruction-detect event, a non-maskable interrupt, a level-1 external line, an arithmetic overflow event, a timer/decrementer event and a level-4 external line. Each source has its own pending latch. The two external lines are captured on a rising edge. The other four arrive as single-cycle strobes.

When the core raises its service-request strobe, the block looks at the pending latches and the current 4-bit interrupt mask. It picks the first eligible source in a fixed priority chain. In the following cycle it presents a valid strobe with that source's vector address, the mask value the core must load, and a flag that tells the core to advance its program counter by one word. In the same edge it clears the latch of the chosen source and no other. A latch is cleared whatever level its input line has at that moment. An external line that is still held high therefore produces no second service until it falls and rises again.

Top module: `irq_vector_arbiter`

## Requirements
- R1: Pending sources win in the fixed order macro-instruction-detect, NMI, level-1 external, overflow, decrementer, level-4 external; only the winner is reported.
- R2: Macro-instruction-detect yields vector 0x0008, new mask 1 and a set PC-increment flag, and it is taken whatever the current mask is.
- R3: NMI yields vector 0xFFFC and new mask 0, and it is taken whatever the current mask is.
- R4: The level-1 external source yields vector 0x0004 and new mask 0.
- R5: Overflow yields vector 0x0008, new mask 1 and a clear PC-increment flag.
- R6: The decrementer yields vector 0x000C and new mask 2.
- R7: The level-4 external source yields vector 0x0010 and new mask 3.
- R8: A maskable source with level n (level-1 external n=1, overflow n=2, decrementer n=3, level-4 external n=4) is eligible only while n is less than or equal to cur_mask.
- R9: The external latches are set by a rising edge only. A line held high after its request was serviced causes no further service.
- R10: svc_valid is high for exactly the one cycle after a svc_req cycle in which some source was eligible. Otherwise it is low and svc_vector, svc_mask and svc_pc_inc read zero. Only the serviced source's latch is cleared.
- R11: A new edge or strobe that arrives in the cycle its latch is cleared is kept, so that source is reported again on the next service.
- R12: After reset nothing is pending and svc_valid is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mid_evt | input | 1 | Macro-instruction-detect strobe |
| nmi_evt | input | 1 | Non-maskable interrupt strobe |
| ext1_line | input | 1 | Level-1 external request line, edge captured |
| ovf_evt | input | 1 | Arithmetic overflow strobe |
| dec_evt | input | 1 | Decrementer expiry strobe |
| ext4_line | input | 1 | Level-4 external request line, edge captured |
| cur_mask | input | 4 | Current interrupt mask of the core |
| svc_req | input | 1 | Core asks for the next interrupt |
| svc_valid | output | 1 | A source was granted, one cycle after svc_req |
| svc_vector | output | 16 | Vector address of the granted source |
| svc_mask | output | 4 | Mask value the core must load |
| svc_pc_inc | output | 1 | Core must advance its PC by one word |

## Verification
The risky overlap is a latch being cleared by a service and set by a fresh request in the same clock edge. The bench first leaves the level-4 line's latch pending. It then raises svc_req and a new rising edge on that line in the same cycle. The first service must report level-4, and a second service must report it again. The same sequence is run with a decrementer strobe. Against this, a line that is simply held high through its service must produce no second grant.

// File: rtl/irqarb_pkg.sv
package irqarb_pkg;

  localparam int NUM_SRC = 6;
  localparam int VEC_W   = 16;
  localparam int MASK_W  = 4;

  // Source index doubles as priority rank: lower index wins.
  typedef enum int {
    SRC_MID  = 0,
    SRC_NMI  = 1,
    SRC_EXT1 = 2,
    SRC_OVF  = 3,
    SRC_DEC  = 4,
    SRC_EXT4 = 5
  } src_e;

  function automatic logic [VEC_W-1:0] vector_of(input int idx);
    case (idx)
      SRC_MID:  vector_of = 16'h0008;
      SRC_NMI:  vector_of = 16'hFFFC;
      SRC_EXT1: vector_of = 16'h0004;
      SRC_OVF:  vector_of = 16'h0008;
      SRC_DEC:  vector_of = 16'h000C;
      default:  vector_of = 16'h0010;
    endcase
  endfunction

  function automatic logic [MASK_W-1:0] newmask_of(input int idx);
    case (idx)
      SRC_MID:  newmask_of = 4'd1;
      SRC_NMI:  newmask_of = 4'd0;
      SRC_EXT1: newmask_of = 4'd0;
      SRC_OVF:  newmask_of = 4'd1;
      SRC_DEC:  newmask_of = 4'd2;
      default:  newmask_of = 4'd3;
    endcase
  endfunction

  function automatic logic [MASK_W-1:0] level_of(input int idx);
    case (idx)
      SRC_EXT1: level_of = 4'd1;
      SRC_OVF:  level_of = 4'd2;
      SRC_DEC:  level_of = 4'd3;
      SRC_EXT4: level_of = 4'd4;
      default:  level_of = 4'd0;
    endcase
  endfunction

  function automatic bit is_maskable(input int idx);
    return (idx != SRC_MID) && (idx != SRC_NMI);
  endfunction

  function automatic bit is_edge_src(input int idx);
    return (idx == SRC_EXT1) || (idx == SRC_EXT4);
  endfunction

  function automatic bit wants_pc_inc(input int idx);
    return idx == SRC_MID;
  endfunction

endpackage

// File: rtl/irq_req_latch.sv
module irq_req_latch #(
  parameter bit EDGE_MODE = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic req_in,
  input  logic clr,
  output logic pend
);

  logic set_now;
  logic pend_d;
  logic pend_q;

  generate
    if (EDGE_MODE) begin : g_edge
      logic prev_q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prev_q <= 1'b0;
        else        prev_q <= req_in;
      end
      assign set_now = req_in & ~prev_q;
    end else begin : g_strobe
      assign set_now = req_in;
    end
  endgenerate

  // A set in the same cycle as a clear is kept.
  always_comb begin
    pend_d = pend_q;
    if (clr)     pend_d = 1'b0;
    if (set_now) pend_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pend_q <= 1'b0;
    else        pend_q <= pend_d;
  end

  assign pend = pend_q;

  // R11
  set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    set_now |=> pend_q);

  // R9
  clear_sticks_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (clr && !set_now) |=> !pend_q);

endmodule

// File: rtl/irq_priority_select.sv
module irq_priority_select
  import irqarb_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NUM_SRC-1:0] pend,
  input  logic [MASK_W-1:0]  cur_mask,
  output logic [NUM_SRC-1:0] grant,
  output logic               any_grant,
  output logic [VEC_W-1:0]   vec,
  output logic [MASK_W-1:0]  new_mask,
  output logic               pc_inc
);

  logic [NUM_SRC-1:0] elig;
  logic [VEC_W-1:0]   vec_part  [NUM_SRC];
  logic [MASK_W-1:0]  mask_part [NUM_SRC];
  logic [NUM_SRC-1:0] pc_part;

  genvar g;
  generate
    for (g = 0; g < NUM_SRC; g++) begin : g_src
      if (is_maskable(g)) begin : g_mask
        assign elig[g] = pend[g] && (level_of(g) <= cur_mask);
      end else begin : g_nomask
        assign elig[g] = pend[g];
      end
      assign vec_part[g]  = grant[g] ? vector_of(g)  : '0;
      assign mask_part[g] = grant[g] ? newmask_of(g) : '0;
      assign pc_part[g]   = grant[g] & wants_pc_inc(g);
    end
  endgenerate

  // Isolate the lowest set bit: rank 0 is the highest priority.
  assign grant     = elig & (~elig + 1'b1);
  assign any_grant = |elig;

  always_comb begin
    vec      = '0;
    new_mask = '0;
    for (int i = 0; i < NUM_SRC; i++) begin
      vec      = vec | vec_part[i];
      new_mask = new_mask | mask_part[i];
    end
  end
  assign pc_inc = |pc_part;

  // R1
  single_grant_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(grant));

  // R1
  grant_pending_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (grant & ~pend) == '0);

  // R8
  ext4_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
    grant[SRC_EXT4] |-> (cur_mask >= 4'd4));

  // R8
  ext1_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
    grant[SRC_EXT1] |-> (cur_mask != 4'd0));

endmodule

// File: rtl/irq_vector_arbiter.sv
module irq_vector_arbiter
  import irqarb_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              mid_evt,
  input  logic              nmi_evt,
  input  logic              ext1_line,
  input  logic              ovf_evt,
  input  logic              dec_evt,
  input  logic              ext4_line,
  input  logic [MASK_W-1:0] cur_mask,
  input  logic              svc_req,
  output logic              svc_valid,
  output logic [VEC_W-1:0]  svc_vector,
  output logic [MASK_W-1:0] svc_mask,
  output logic              svc_pc_inc
);

  logic [NUM_SRC-1:0] src_in;
  logic [NUM_SRC-1:0] pend;
  logic [NUM_SRC-1:0] clr;
  logic [NUM_SRC-1:0] grant;
  logic               any_grant;
  logic [VEC_W-1:0]   sel_vec;
  logic [MASK_W-1:0]  sel_mask;
  logic               sel_pc;

  logic               valid_d, valid_q;
  logic [VEC_W-1:0]   vec_d, vec_q;
  logic [MASK_W-1:0]  mask_d, mask_q;
  logic               pc_d, pc_q;
  logic               load_en;

  assign src_in[SRC_MID]  = mid_evt;
  assign src_in[SRC_NMI]  = nmi_evt;
  assign src_in[SRC_EXT1] = ext1_line;
  assign src_in[SRC_OVF]  = ovf_evt;
  assign src_in[SRC_DEC]  = dec_evt;
  assign src_in[SRC_EXT4] = ext4_line;

  genvar g;
  generate
    for (g = 0; g < NUM_SRC; g++) begin : g_latch
      irq_req_latch #(.EDGE_MODE(is_edge_src(g))) u_latch (
        .clk    (clk),
        .rst_n  (rst_n),
        .req_in (src_in[g]),
        .clr    (clr[g]),
        .pend   (pend[g])
      );
    end
  endgenerate

  irq_priority_select u_sel (
    .clk       (clk),
    .rst_n     (rst_n),
    .pend      (pend),
    .cur_mask  (cur_mask),
    .grant     (grant),
    .any_grant (any_grant),
    .vec       (sel_vec),
    .new_mask  (sel_mask),
    .pc_inc    (sel_pc)
  );

  assign load_en = svc_req & any_grant;
  assign clr     = grant & {NUM_SRC{svc_req}};

  always_comb begin
    valid_d = 1'b0;
    vec_d   = '0;
    mask_d  = '0;
    pc_d    = 1'b0;
    if (load_en) begin
      valid_d = 1'b1;
      vec_d   = sel_vec;
      mask_d  = sel_mask;
      pc_d    = sel_pc;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= 1'b0;
      vec_q   <= '0;
      mask_q  <= '0;
      pc_q    <= 1'b0;
    end else begin
      valid_q <= valid_d;
      vec_q   <= vec_d;
      mask_q  <= mask_d;
      pc_q    <= pc_d;
    end
  end

  assign svc_valid  = valid_q;
  assign svc_vector = vec_q;
  assign svc_mask   = mask_q;
  assign svc_pc_inc = pc_q;

  // R10
  valid_follows_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    svc_valid |-> $past(svc_req));

  // R10
  idle_outputs_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !svc_valid |-> (svc_vector == '0 && svc_mask == '0 && !svc_pc_inc));

  // R3
  nmi_vector_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (svc_req && pend[SRC_NMI] && !pend[SRC_MID]) |=>
      (svc_valid && svc_vector == 16'hFFFC && svc_mask == 4'd0));

  // R2
  mid_pc_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (svc_req && pend[SRC_MID]) |=> (svc_valid && svc_pc_inc && svc_mask == 4'd1));

  // R10
  cleared_after_grant_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (clr[SRC_NMI] && !nmi_evt) |=> !pend[SRC_NMI]);

endmodule

// File: tb/irq_vector_arbiter_tb.sv
module irq_vector_arbiter_tb;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        mid_evt, nmi_evt, ext1_line, ovf_evt, dec_evt, ext4_line;
  logic [3:0]  cur_mask;
  logic        svc_req;
  logic        svc_valid;
  logic [15:0] svc_vector;
  logic [3:0]  svc_mask;
  logic        svc_pc_inc;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #10 clk = ~clk;

  irq_vector_arbiter u_dut (
    .clk        (clk),
    .rst_n      (rst_n),
    .mid_evt    (mid_evt),
    .nmi_evt    (nmi_evt),
    .ext1_line  (ext1_line),
    .ovf_evt    (ovf_evt),
    .dec_evt    (dec_evt),
    .ext4_line  (ext4_line),
    .cur_mask   (cur_mask),
    .svc_req    (svc_req),
    .svc_valid  (svc_valid),
    .svc_vector (svc_vector),
    .svc_mask   (svc_mask),
    .svc_pc_inc (svc_pc_inc)
  );

  // Entry: {req tag 4, sources 6 (ext4,dec,ovf,ext1,nmi,mid), mask 4,
  //         valid 1, vector 16, new mask 4, pc_inc 1} = 36 bits
  localparam int NV = 16;
  localparam logic [35:0] TBL [NV] = '{
    {4'd2,  6'b000001, 4'h0, 1'b1, 16'h0008, 4'd1, 1'b1}, // R2
    {4'd3,  6'b000010, 4'h0, 1'b1, 16'hFFFC, 4'd0, 1'b0}, // R3
    {4'd4,  6'b000100, 4'h1, 1'b1, 16'h0004, 4'd0, 1'b0}, // R4
    {4'd5,  6'b001000, 4'h2, 1'b1, 16'h0008, 4'd1, 1'b0}, // R5
    {4'd6,  6'b010000, 4'h3, 1'b1, 16'h000C, 4'd2, 1'b0}, // R6
    {4'd7,  6'b100000, 4'h4, 1'b1, 16'h0010, 4'd3, 1'b0}, // R7
    {4'd1,  6'b111111, 4'hF, 1'b1, 16'h0008, 4'd1, 1'b1}, // R1
    {4'd1,  6'b111110, 4'hF, 1'b1, 16'hFFFC, 4'd0, 1'b0}, // R1
    {4'd1,  6'b111100, 4'hF, 1'b1, 16'h0004, 4'd0, 1'b0}, // R1
    {4'd1,  6'b111000, 4'hF, 1'b1, 16'h0008, 4'd1, 1'b0}, // R1
    {4'd1,  6'b110000, 4'hF, 1'b1, 16'h000C, 4'd2, 1'b0}, // R1
    {4'd8,  6'b100000, 4'h3, 1'b0, 16'h0000, 4'd0, 1'b0}, // R8
    {4'd8,  6'b000100, 4'h0, 1'b0, 16'h0000, 4'd0, 1'b0}, // R8
    {4'd8,  6'b000011, 4'h0, 1'b1, 16'h0008, 4'd1, 1'b1}, // R8
    {4'd8,  6'b111000, 4'h2, 1'b1, 16'h0008, 4'd1, 1'b0}, // R8
    {4'd10, 6'b000000, 4'hF, 1'b0, 16'h0000, 4'd0, 1'b0}  // R10
  };

  task automatic check_out(input int req, input logic ev, input logic [15:0] evec,
                           input logic [3:0] em, input logic epc);
    checks++;
    if (svc_valid !== ev || svc_vector !== evec || svc_mask !== em || svc_pc_inc !== epc) begin
      fails++;
      $display("FAIL R%0d: got valid=%0b vec=%04h mask=%0d pc=%0b, expected valid=%0b vec=%04h mask=%0d pc=%0b",
               req, svc_valid, svc_vector, svc_mask, svc_pc_inc, ev, evec, em, epc);
    end
  endtask

  // Sources pulse high for one cycle; external lines rise then fall.
  task automatic raise(input logic [5:0] s);
    @(negedge clk);
    mid_evt = s[0]; nmi_evt = s[1]; ext1_line = s[2];
    ovf_evt = s[3]; dec_evt = s[4]; ext4_line = s[5];
    @(negedge clk);
    mid_evt = 0; nmi_evt = 0; ext1_line = 0; ovf_evt = 0; dec_evt = 0; ext4_line = 0;
  endtask

  // Drive svc_req for one cycle; returns at the negedge where outputs are valid.
  task automatic service(input logic [3:0] m);
    @(negedge clk);
    cur_mask = m;
    svc_req  = 1'b1;
    @(negedge clk);
    svc_req  = 1'b0;
  endtask

  task automatic drain();
    for (int k = 0; k < 8; k++) service(4'hF);
  endtask

  initial begin
    #4000000;
    if (!done) begin
      fails++;
      checks++;
      $display("FAIL watchdog: got timeout, expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    rst_n = 0; svc_req = 0; cur_mask = 0;
    mid_evt = 0; nmi_evt = 0; ext1_line = 0; ovf_evt = 0; dec_evt = 0; ext4_line = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    check_out(12, 1'b0, 16'h0, 4'd0, 1'b0); // R12 reset state
    service(4'hF);
    check_out(12, 1'b0, 16'h0, 4'd0, 1'b0); // R12 nothing pending

    for (int i = 0; i < NV; i++) begin
      raise(TBL[i][31:26]);
      service(TBL[i][25:22]);
      check_out(int'(TBL[i][35:32]), TBL[i][21], TBL[i][20:5], TBL[i][4:1], TBL[i][0]);
      drain();
    end

    // R10: strobe lasts one cycle, only the winner is cleared
    raise(6'b000011);
    service(4'h0);
    check_out(10, 1'b1, 16'h0008, 4'd1, 1'b1);
    @(negedge clk);
    check_out(10, 1'b0, 16'h0, 4'd0, 1'b0);
    service(4'h0);
    check_out(10, 1'b1, 16'hFFFC, 4'd0, 1'b0);
    service(4'h0);
    check_out(10, 1'b0, 16'h0, 4'd0, 1'b0);

    // R9: held line serviced once, new edge serviced again
    @(negedge clk); ext1_line = 1;
    service(4'hF);
    check_out(9, 1'b1, 16'h0004, 4'd0, 1'b0);
    service(4'hF);
    check_out(9, 1'b0, 16'h0, 4'd0, 1'b0);
    @(negedge clk); ext1_line = 0;
    @(negedge clk); ext1_line = 1;
    service(4'hF);
    check_out(9, 1'b1, 16'h0004, 4'd0, 1'b0);
    ext1_line = 0;
    drain();

    // R11: fresh edge on level-4 line during its own clear
    raise(6'b100000);
    @(negedge clk);
    cur_mask = 4'hF; svc_req = 1; ext4_line = 1;
    @(negedge clk);
    svc_req = 0; ext4_line = 0;
    check_out(11, 1'b1, 16'h0010, 4'd3, 1'b0);
    service(4'hF);
    check_out(11, 1'b1, 16'h0010, 4'd3, 1'b0);
    service(4'hF);
    check_out(11, 1'b0, 16'h0, 4'd0, 1'b0);

    // R11: decrementer strobe during its own clear
    raise(6'b010000);
    @(negedge clk);
    cur_mask = 4'hF; svc_req = 1; dec_evt = 1;
    @(negedge clk);
    svc_req = 0; dec_evt = 0;
    check_out(11, 1'b1, 16'h000C, 4'd2, 1'b0);
    service(4'hF);
    check_out(11, 1'b1, 16'h000C, 4'd2, 1'b0);
    service(4'hF);
    check_out(11, 1'b0, 16'h0, 4'd0, 1'b0);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule